// File: doc/BRIEF.md
# Packed-BCD Calendar Counter with Week Numbering

This block keeps the running time and date of a real-time clock. Each one-cycle pulse on `tick` marks 10 ms. On that pulse the block advances a chain of packed-BCD registers in a single clock edge. The chain runs from hundredths of a second through seconds, minutes, hours, day of month, month and two-digit year. A weekday counter and an ISO-like week counter run beside the chain. The hours register counts in either a 24-hour or a 12-hour format, chosen by `fmt_12h`. February takes its length from a leap-year test on the year register.

A commit path from elsewhere in the chip can overwrite every register at once with the parallel load port. Software can therefore leave out-of-range values in the registers. The block does not reject such values. It keeps counting them up until their units digit passes 9, and then it clears them to 00. At the start of each year the week counter is seeded from the new weekday, so that the first days of a year can belong to week 0.

Top module: `bcd_cal_core`

## Requirements
- R1: After reset, the registers read hundredths 00, seconds 00, minutes 00, hours 00, date 01, month 01, year 00, weekday 06 and week 00.
- R2: A `tick` pulse raises hundredths by one on the next clock edge. When neither `tick` nor `load` is high, no register changes.
- R3: Hundredths wrap from 99 to 00, and seconds and minutes wrap from 59 to 00. Each wrap carries one into the next field on the same edge.
- R4: With `fmt_12h` low, hours run from 00 to 23. A carry out of 23 returns hours to 00 and advances the date, the weekday and the week logic.
- R5: With `fmt_12h` high, bits 6:0 of hours count 12, 01, ..., 11, and bit 7 is the PM flag (1 = PM). The step 11→12 toggles bit 7. The step from PM 11 to AM 12 advances the day.
- R6: The last day of each month is 30 for months 04, 06, 09 and 11, and 31 for the other months. February ends on 29 when the year is a multiple of 4 (00 counts) and on 28 otherwise. After the last day comes date 01 of the next month.
- R7: Month 12 wraps to 01, and the same edge raises the year. Year 99 wraps to 00.
- R8: The weekday counts 1 to 7 with Monday as 1. Day 7 is followed by day 1.
- R9: Within a year, the week number rises by one (BCD) when the weekday steps from 7 to 1, and it holds on every other day step.
- R10: When the date reaches January 1, the week number becomes 00 if the new weekday is 5, 6 or 7, and 01 otherwise.
- R11: A field holding an out-of-range value steps its units digit. When its units digit is 9 or more, the next step clears the field to 00 and sends no carry onward. For example, seconds B2 step to B3, and seconds B9 step to 00 while minutes stay unchanged.
- R12: `load` copies all nine load inputs into the registers on the next edge and takes priority over a `tick` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 10 ms advance pulse |
| fmt_12h | input | 1 | 1 = 12-hour hours with PM flag in bit 7, 0 = 24-hour |
| load | input | 1 | Parallel load strobe |
| ld_hund | input | 8 | Load value, hundredths |
| ld_sec | input | 8 | Load value, seconds |
| ld_min | input | 8 | Load value, minutes |
| ld_hour | input | 8 | Load value, hours |
| ld_date | input | 8 | Load value, day of month |
| ld_month | input | 8 | Load value, month |
| ld_year | input | 8 | Load value, year |
| ld_wday | input | 8 | Load value, weekday |
| ld_week | input | 8 | Load value, week number |
| q_hund | output | 8 | Hundredths, BCD |
| q_sec | output | 8 | Seconds, BCD |
| q_min | output | 8 | Minutes, BCD |
| q_hour | output | 8 | Hours, BCD (PM flag in bit 7 in 12-hour mode) |
| q_date | output | 8 | Day of month, BCD |
| q_month | output | 8 | Month, BCD |
| q_year | output | 8 | Year, BCD |
| q_wday | output | 8 | Weekday 1..7, BCD |
| q_week | output | 8 | Week number, BCD |

## Verification
Every register is an output, so a wrong step of any field shows up on the port one edge after the tick that caused it. A wrong carry condition, such as a bad month length or a misplaced 12-hour turnover, stays hidden until the chain reaches that boundary. The tests therefore load each field to one tick before its boundary and fire a single tick. A mistake in the week seed shows only on January 1, in the week number that appears on that same edge.

// File: rtl/bcd_cal_pkg.sv
// Package: shared BCD arithmetic for the calendar counter.
// Assumes byte-wide packed BCD values, tens digit in bits 7:4.
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] val;
        logic       wrap;
    } bcd_res_t;

    // Next value of a field on one step: wraps lim -> minv, and clears out-of-range values on units >= 9
    function automatic bcd_res_t bcd_next(input logic [7:0] v,
                                          input logic [7:0] lim,
                                          input logic [7:0] minv);
        bcd_res_t r;
        r.wrap = 1'b0;
        if (v == lim) begin
            r.val  = minv;
            r.wrap = 1'b1;
        end else if (v[3:0] >= 4'd9) begin
            if ((v[3:0] > 4'd9) || (v > lim))
                r.val = 8'h00;
            else
                r.val = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.val = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // Leap test on a two-digit BCD year: 10 is 2 mod 4, so an odd tens digit adds 2
    function automatic logic is_leap(input logic [7:0] y);
        logic [3:0] m;
        m = y[3:0] + {2'b00, y[4], 1'b0};
        return (m & 4'd3) == 4'd0;
    endfunction

    // Last day of a BCD month; unknown months get 31
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        logic [7:0] d;
        case (mon)
            8'h02:                      d = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcd_field.sv
// Module: one packed-BCD counter field with parallel load.
// Steps once per cycle when step is high, wrapping from lim to MINV.
// Assumes lim is a legal BCD value; load takes priority over step.
module bcd_field
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] RSTV = 8'h00,
    parameter logic [7:0] MINV = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       step,
    input  logic [7:0] lim,
    output logic [7:0] q
);

    bcd_res_t nxt;

    // Compute the stepped value of the field
    always_comb nxt = bcd_next(q, lim, MINV);

    // Register: reset, load, or step
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RSTV;
        else if (ld)   q <= ld_val;
        else if (step) q <= nxt.val;
    end

endmodule

// File: rtl/bcd_hour_field.sv
// Module: hours register in 24-hour or 12-hour format.
// In 12-hour mode bits 6:0 count 12,01..11 and bit 7 is the PM flag.
// day_carry is combinational and is high when this step ends the day.
module bcd_hour_field
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] RSTV = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt12,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       step,
    output logic [7:0] q,
    output logic       day_carry
);

    localparam logic [7:0] LIM24 = 8'h23;
    localparam logic [7:0] LIM12 = 8'h12;

    bcd_res_t   r24;
    bcd_res_t   r12;
    logic [7:0] nxt;
    logic       wrap;

    // Select the next hour value and the day-end condition for the active format
    always_comb begin
        r24  = bcd_next(q, LIM24, 8'h00);
        r12  = bcd_next({1'b0, q[6:0]}, LIM12, 8'h01);
        nxt  = r24.val;
        wrap = r24.wrap;
        if (fmt12) begin
            wrap = 1'b0;
            if (q[6:0] == 7'h12) begin
                nxt = {q[7], 7'h01};
            end else if (q[6:0] == 7'h11) begin
                nxt  = {~q[7], 7'h12};
                wrap = q[7];
            end else begin
                nxt = {q[7], r12.val[6:0]};
            end
        end
        day_carry = step && wrap;
    end

    // Register: reset, load, or step
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RSTV;
        else if (ld)   q <= ld_val;
        else if (step) q <= nxt;
    end

endmodule

// File: rtl/bcd_week_field.sv
// Module: week-number register.
// On a day step it reseeds on a new year (00 if the new weekday is 5..7, else 01),
// or counts up when the weekday wraps from 7 to 1. Assumes weekdays 1..7.
module bcd_week_field
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] RSTV     = 8'h00,
    parameter logic [7:0] WEEK_LIM = 8'h53,
    parameter logic [7:0] WDAY_LIM = 8'h07,
    parameter logic [7:0] LATE_DAY = 8'h05
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       day_step,
    input  logic       new_year,
    input  logic [7:0] wday,
    output logic [7:0] q
);

    bcd_res_t   wk_nxt;
    bcd_res_t   wd_nxt;
    logic [7:0] seed;

    // Derive the new weekday, the seed week and the counted week
    always_comb begin
        wd_nxt = bcd_next(wday, WDAY_LIM, 8'h01);
        wk_nxt = bcd_next(q, WEEK_LIM, 8'h00);
        seed   = (wd_nxt.val >= LATE_DAY && wd_nxt.val <= WDAY_LIM) ? 8'h00 : 8'h01;
    end

    // Register: reset, load, reseed at year start, or count on a Monday
    always_ff @(posedge clk) begin
        if (!rst_n)                      q <= RSTV;
        else if (ld)                     q <= ld_val;
        else if (day_step && new_year)   q <= seed;
        else if (day_step && wd_nxt.wrap) q <= wk_nxt.val;
    end

endmodule

// File: rtl/bcd_cal_core.sv
// Module: live timekeeping core. One tick (10 ms) advances the whole BCD
// chain in a single edge: hundredths..year, weekday and week number.
// Assumes tick is a one-cycle pulse; load overrides tick.
module bcd_cal_core
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] RST_DATE  = 8'h01,
    parameter logic [7:0] RST_MONTH = 8'h01,
    parameter logic [7:0] RST_YEAR  = 8'h00,
    parameter logic [7:0] RST_WDAY  = 8'h06,
    parameter logic [7:0] RST_WEEK  = 8'h00,
    parameter int         SUB_N     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fmt_12h,
    input  logic       load,
    input  logic [7:0] ld_hund,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_week,
    output logic [7:0] q_hund,
    output logic [7:0] q_sec,
    output logic [7:0] q_min,
    output logic [7:0] q_hour,
    output logic [7:0] q_date,
    output logic [7:0] q_month,
    output logic [7:0] q_year,
    output logic [7:0] q_wday,
    output logic [7:0] q_week
);

    localparam int         SUB_W    = 8 * SUB_N;
    localparam logic [SUB_W-1:0] SUB_LIM = {8'h59, 8'h59, 8'h99};
    localparam logic [7:0] MONTH_LIM = 8'h12;
    localparam logic [7:0] YEAR_LIM  = 8'h99;
    localparam logic [7:0] WDAY_LIM  = 8'h07;

    logic [SUB_W-1:0] sub_ld;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_N:0]   sub_step;
    logic             day_step;
    logic [7:0]       date_lim;
    logic             month_step;
    logic             year_step;

    // Gather the sub-hour load values and outputs in chain order
    always_comb begin
        sub_ld   = {ld_min, ld_sec, ld_hund};
        q_hund   = sub_q[7:0];
        q_sec    = sub_q[15:8];
        q_min    = sub_q[23:16];
    end

    assign sub_step[0] = tick;

    // Hundredths, seconds and minutes: identical fields in a ripple chain
    for (genvar i = 0; i < SUB_N; i++) begin : g_sub
        bcd_field #(.RSTV(8'h00), .MINV(8'h00)) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (load),
            .ld_val (sub_ld[i*8 +: 8]),
            .step   (sub_step[i]),
            .lim    (SUB_LIM[i*8 +: 8]),
            .q      (sub_q[i*8 +: 8])
        );
        assign sub_step[i+1] = sub_step[i] && (sub_q[i*8 +: 8] == SUB_LIM[i*8 +: 8]);
    end

    bcd_hour_field #(.RSTV(8'h00)) u_hour (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt12     (fmt_12h),
        .ld        (load),
        .ld_val    (ld_hour),
        .step      (sub_step[SUB_N]),
        .q         (q_hour),
        .day_carry (day_step)
    );

    // Month length for the date wrap, and carries up the calendar part of the chain
    always_comb begin
        date_lim   = month_days(q_month, is_leap(q_year));
        month_step = day_step && (q_date == date_lim);
        year_step  = month_step && (q_month == MONTH_LIM);
    end

    bcd_field #(.RSTV(RST_DATE), .MINV(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(ld_date),
        .step(day_step), .lim(date_lim), .q(q_date)
    );

    bcd_field #(.RSTV(RST_MONTH), .MINV(8'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(ld_month),
        .step(month_step), .lim(MONTH_LIM), .q(q_month)
    );

    bcd_field #(.RSTV(RST_YEAR), .MINV(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(ld_year),
        .step(year_step), .lim(YEAR_LIM), .q(q_year)
    );

    bcd_field #(.RSTV(RST_WDAY), .MINV(8'h01)) u_wday (
        .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(ld_wday),
        .step(day_step), .lim(WDAY_LIM), .q(q_wday)
    );

    bcd_week_field #(.RSTV(RST_WEEK), .WDAY_LIM(WDAY_LIM)) u_week (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (load),
        .ld_val   (ld_week),
        .day_step (day_step),
        .new_year (year_step),
        .wday     (q_wday),
        .q        (q_week)
    );

endmodule

// File: rtl/bcd_cal_chk.sv
// Module: port-level checker for bcd_cal_core, attached by bind.
module bcd_cal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       fmt_12h,
    input logic       load,
    input logic [7:0] ld_hund,
    input logic [7:0] ld_sec,
    input logic [7:0] ld_min,
    input logic [7:0] ld_hour,
    input logic [7:0] ld_date,
    input logic [7:0] ld_month,
    input logic [7:0] ld_year,
    input logic [7:0] ld_wday,
    input logic [7:0] ld_week,
    input logic [7:0] q_hund,
    input logic [7:0] q_sec,
    input logic [7:0] q_min,
    input logic [7:0] q_hour,
    input logic [7:0] q_date,
    input logic [7:0] q_month,
    input logic [7:0] q_year,
    input logic [7:0] q_wday,
    input logic [7:0] q_week
);

    logic end_of_hour;
    assign end_of_hour = tick && !load && q_hund == 8'h99 && q_sec == 8'h59 && q_min == 8'h59;

    // R2: every tick moves hundredths
    a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> q_hund != $past(q_hund));

    // R2: idle cycles hold every register
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(q_hund) && $stable(q_sec) && $stable(q_min) &&
                              $stable(q_hour) && $stable(q_date) && $stable(q_month) &&
                              $stable(q_year) && $stable(q_wday) && $stable(q_week)));

    // R12: load copies every input and beats tick
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_hund == $past(ld_hund) && q_sec == $past(ld_sec) && q_min == $past(ld_min) &&
                  q_hour == $past(ld_hour) && q_date == $past(ld_date) &&
                  q_month == $past(ld_month) && q_year == $past(ld_year) &&
                  q_wday == $past(ld_wday) && q_week == $past(ld_week)));

    // R8: Sunday at day end becomes Monday
    a_r8_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_hour && !fmt_12h && q_hour == 8'h23 && q_wday == 8'h07) |=> q_wday == 8'h01);

    // R5: 12 o'clock steps to 01 keeping the PM flag
    a_r5_noon_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_hour && fmt_12h && q_hour[6:0] == 7'h12) |=> q_hour == {$past(q_hour[7]), 7'h01});

    // R4: in 24-hour mode a day end clears hours
    a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_hour && !fmt_12h && q_hour == 8'h23) |=> q_hour == 8'h00);

endmodule

bind bcd_cal_core bcd_cal_chk u_chk (.*);

// File: tb/sim_bcd_cal_core.sv
// Directed bench for bcd_cal_core: one task per scenario.
module sim_bcd_cal_core;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic fmt_12h = 1'b0;
    logic load = 1'b0;
    logic [7:0] ld_hund = 8'h00, ld_sec = 8'h00, ld_min = 8'h00, ld_hour = 8'h00;
    logic [7:0] ld_date = 8'h01, ld_month = 8'h01, ld_year = 8'h00, ld_wday = 8'h01, ld_week = 8'h00;
    logic [7:0] q_hund, q_sec, q_min, q_hour, q_date, q_month, q_year, q_wday, q_week;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_cal_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_12h(fmt_12h), .load(load),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .ld_wday(ld_wday), .ld_week(ld_week),
        .q_hund(q_hund), .q_sec(q_sec), .q_min(q_min), .q_hour(q_hour),
        .q_date(q_date), .q_month(q_month), .q_year(q_year),
        .q_wday(q_wday), .q_week(q_week)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_all(input logic [7:0] h, s, m, hr, d, mo, y, wd, wk);
        @(negedge clk);
        ld_hund = h; ld_sec = s; ld_min = m; ld_hour = hr;
        ld_date = d; ld_month = mo; ld_year = y; ld_wday = wd; ld_week = wk;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Load one tick before midnight on a given date, then tick
    task automatic day_end(input logic [7:0] d, mo, y, wd, wk);
        load_all(8'h99, 8'h59, 8'h59, 8'h23, d, mo, y, wd, wk);
        tick_once();
    endtask

    task automatic t_reset();
        chk("R1 hund", q_hund, 8'h00);   chk("R1 sec", q_sec, 8'h00);
        chk("R1 min", q_min, 8'h00);     chk("R1 hour", q_hour, 8'h00);
        chk("R1 date", q_date, 8'h01);   chk("R1 month", q_month, 8'h01);
        chk("R1 year", q_year, 8'h00);   chk("R1 wday", q_wday, 8'h06);
        chk("R1 week", q_week, 8'h00);
    endtask

    task automatic t_tick_idle();
        tick_once();
        chk("R2 hund after tick", q_hund, 8'h01);
        chk("R2 sec unchanged", q_sec, 8'h00);
        repeat (3) @(negedge clk);
        chk("R2 hund idle", q_hund, 8'h01);
        chk("R2 date idle", q_date, 8'h01);
    endtask

    task automatic t_cascade();
        load_all(8'h99, 8'h59, 8'h14, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R3 hund wrap", q_hund, 8'h00);
        chk("R3 sec wrap", q_sec, 8'h00);
        chk("R3 min carry", q_min, 8'h15);
        chk("R3 hour held", q_hour, 8'h10);
        load_all(8'h99, 8'h59, 8'h59, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R3 min wrap", q_min, 8'h00);
        chk("R3 hour carry", q_hour, 8'h11);
        load_all(8'h49, 8'h09, 8'h00, 8'h00, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R3 hund decade", q_hund, 8'h50);
    endtask

    task automatic t_24h();
        fmt_12h = 1'b0;
        day_end(8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        chk("R4 hour 00", q_hour, 8'h00);
        chk("R4 date next", q_date, 8'h06);
        chk("R4 wday next", q_wday, 8'h03);
        chk("R9 week held midweek", q_week, 8'h10);
    endtask

    task automatic t_12h();
        fmt_12h = 1'b1;
        load_all(8'h99, 8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        tick_once();
        chk("R5 am11 to pm12", q_hour, 8'h92);
        chk("R5 date held at noon", q_date, 8'h05);
        load_all(8'h99, 8'h59, 8'h59, 8'h91, 8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        tick_once();
        chk("R5 pm11 to am12", q_hour, 8'h12);
        chk("R5 date at midnight", q_date, 8'h06);
        load_all(8'h99, 8'h59, 8'h59, 8'h12, 8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        tick_once();
        chk("R5 am12 to 01", q_hour, 8'h01);
        load_all(8'h99, 8'h59, 8'h59, 8'h92, 8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        tick_once();
        chk("R5 pm12 to pm01", q_hour, 8'h81);
        load_all(8'h99, 8'h59, 8'h59, 8'h09, 8'h05, 8'h03, 8'h24, 8'h02, 8'h10);
        tick_once();
        chk("R5 09 to 10", q_hour, 8'h10);
        fmt_12h = 1'b0;
    endtask

    task automatic t_months();
        day_end(8'h28, 8'h02, 8'h24, 8'h01, 8'h09);
        chk("R6 leap feb 29", q_date, 8'h29);   chk("R6 leap month held", q_month, 8'h02);
        day_end(8'h29, 8'h02, 8'h24, 8'h01, 8'h09);
        chk("R6 leap feb end date", q_date, 8'h01); chk("R6 leap feb end month", q_month, 8'h03);
        day_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h09);
        chk("R6 feb 23 date", q_date, 8'h01);   chk("R6 feb 23 month", q_month, 8'h03);
        day_end(8'h28, 8'h02, 8'h10, 8'h01, 8'h09);
        chk("R6 year 10 not leap", q_month, 8'h03);
        day_end(8'h28, 8'h02, 8'h12, 8'h01, 8'h09);
        chk("R6 year 12 leap", q_date, 8'h29);
        day_end(8'h28, 8'h02, 8'h00, 8'h01, 8'h09);
        chk("R6 year 00 leap", q_date, 8'h29);
        day_end(8'h30, 8'h04, 8'h24, 8'h01, 8'h09);
        chk("R6 april end date", q_date, 8'h01); chk("R6 april end month", q_month, 8'h05);
        day_end(8'h29, 8'h04, 8'h24, 8'h01, 8'h09);
        chk("R6 april 30", q_date, 8'h30);
        day_end(8'h31, 8'h01, 8'h24, 8'h01, 8'h09);
        chk("R6 january end", q_month, 8'h02);
        day_end(8'h30, 8'h08, 8'h24, 8'h01, 8'h09);
        chk("R6 august 31", q_date, 8'h31);
    endtask

    task automatic t_newyear();
        day_end(8'h31, 8'h12, 8'h24, 8'h07, 8'h52);
        chk("R7 year up", q_year, 8'h25);  chk("R7 month 01", q_month, 8'h01);
        chk("R7 date 01", q_date, 8'h01);  chk("R8 sunday to monday", q_wday, 8'h01);
        chk("R10 monday start week 01", q_week, 8'h01);
        day_end(8'h31, 8'h12, 8'h99, 8'h04, 8'h52);
        chk("R7 year 99 wraps", q_year, 8'h00);
        chk("R10 friday start week 00", q_week, 8'h00);
        day_end(8'h31, 8'h12, 8'h30, 8'h06, 8'h52);
        chk("R10 sunday start week 00", q_week, 8'h00);
        day_end(8'h31, 8'h12, 8'h30, 8'h03, 8'h52);
        chk("R10 thursday start week 01", q_week, 8'h01);
    endtask

    task automatic t_weeks();
        day_end(8'h16, 8'h06, 8'h24, 8'h07, 8'h24);
        chk("R8 wday wraps", q_wday, 8'h01);
        chk("R9 week up", q_week, 8'h25);
        day_end(8'h16, 8'h06, 8'h24, 8'h07, 8'h09);
        chk("R9 week bcd carry", q_week, 8'h10);
    endtask

    task automatic t_illegal();
        load_all(8'h99, 8'hB2, 8'h30, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R11 B2 to B3", q_sec, 8'hB3);
        chk("R11 min held", q_min, 8'h30);
        load_all(8'h99, 8'hB9, 8'h30, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R11 B9 cleared", q_sec, 8'h00);
        chk("R11 no carry", q_min, 8'h30);
        load_all(8'h99, 8'h59, 8'h65, 8'h10, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R11 min 65 to 66", q_min, 8'h66);
        load_all(8'h99, 8'h59, 8'h59, 8'h27, 8'h15, 8'h06, 8'h24, 8'h03, 8'h24);
        tick_once();
        chk("R11 hour 27 to 28", q_hour, 8'h28);
        chk("R11 date held", q_date, 8'h15);
    endtask

    task automatic t_load_priority();
        @(negedge clk);
        ld_hund = 8'h50; ld_sec = 8'h20; ld_min = 8'h10; ld_hour = 8'h08;
        ld_date = 8'h11; ld_month = 8'h07; ld_year = 8'h33; ld_wday = 8'h02; ld_week = 8'h27;
        load = 1'b1; tick = 1'b1;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
        chk("R12 hund from load", q_hund, 8'h50);
        chk("R12 year from load", q_year, 8'h33);
        chk("R12 week from load", q_week, 8'h27);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick_idle();
        t_cascade();
        t_24h();
        t_12h();
        t_months();
        t_newyear();
        t_weeks();
        t_illegal();
        t_load_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule